// File: doc/BRIEF.md
# Dual-Path Macro-Op Decode Merger

This block takes one predecoded fetch window at a time and turns it into an in-order stream of macro-ops. A window covers 16 bytes, split into a lower and an upper aligned 8-byte half. It offers up to six instruction slots. Each slot has a valid bit, a path bit, a half bit, a one-or-two-OP flag and a payload word. A slot marked for the direct path already holds its finished macro-op and goes straight to the output. A slot marked for the vector path uses the low bits of its payload as an entry address into an internal macro-op ROM. A sequencer then walks that ROM until it reaches a word flagged as the end of the sequence.

Each cycle the block presents a bundle of up to three macro-ops to a downstream queue. The bundle uses a valid/ready handshake and fills its lanes from lane 0 upward. A bundle holds either direct-path macro-ops or ROM macro-ops, never both. So an expansion never shares a cycle with a younger direct instruction.

Control is a three-state machine:
- `ST_IDLE` accepts a window. It moves to `ST_SLOTS` when the window is legal and not empty.
- `ST_SLOTS` issues from the oldest pending slot.
  - On a direct slot it emits up to three consecutive direct slots.
  - On a vector slot it emits the first ROM words. It moves to `ST_ROM` if the sequence does not end in that bundle.
  - It returns to `ST_IDLE` once no slot is left pending.
- `ST_ROM` continues a sequence. It goes back to `ST_SLOTS` or `ST_IDLE` when the word that ends the sequence is accepted.
- A flush sends any state to `ST_IDLE`.

Top module: `dual_decode_merge`

## Requirements
- R1: After reset, `win_ready` is 1, and `out_valid` and `win_error` are 0.
- R2: A window is taken on a clock edge where `win_valid` and `win_ready` are both 1. From then on `win_ready` stays 0 while any valid slot of that window has not been emitted. It returns to 1 in the cycle after the bundle holding the last macro-op is accepted.
- R3: Lanes fill contiguously from lane 0, and `out_valid` equals the OR of `out_lane_vld`. A direct bundle carries up to three consecutive pending direct slots in slot order, skipping slots whose valid bit is 0. Each lane carries that slot's payload on `out_mop` (lane k at bits k*16 upward) and its OP flag on `out_two_ops`.
- R4: A vector slot expands from the ROM, starting at the address in payload bits [5:0]. The ROM word at address a has macro-op value 16'hC000 | a, OP flag a[2], and an end-of-sequence flag set when a[1:0] is 3. Addresses advance by one per lane, and up to three words go out per bundle. The sequence ends with the word whose end flag is set.
- R5: A bundle never mixes ROM words and direct slots. The bundle after the end of a sequence starts with the next pending slot.
- R6: Across bundles, macro-ops appear in slot order, and each ROM sequence sits complete at its own slot's position.
- R7: While `out_valid` is 1 and `out_ready` is 0, with no flush, `out_lane_vld`, `out_mop` and `out_two_ops` hold their values on the next cycle.
- R8: A window with more than three valid direct slots in either half (`win_slot_hi` 0 = lower, 1 = upper) is dropped. When that happens:
  - `win_error` is 1 for the one cycle after the accepting edge.
  - `out_valid` stays 0.
  - `win_ready` stays 1.
- R9: A flush drops the pending window and any ROM sequence in progress. On the next cycle `out_valid` is 0, and `win_ready` is 1 once `flush` is low. `win_ready` is 0 while `flush` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous flush of window and sequence |
| win_valid | input | 1 | Window offered |
| win_ready | output | 1 | Block can take a window |
| win_slot_vld | input | 6 | Per-slot valid |
| win_slot_vec | input | 6 | Per-slot path, 1 = ROM expansion |
| win_slot_hi | input | 6 | Per-slot half, 1 = upper 8 bytes |
| win_slot_two_ops | input | 6 | Per-slot OP count flag, 1 = two OPs |
| win_slot_data | input | 96 | Per-slot payload, slot i at bits i*16 upward |
| win_error | output | 1 | One-cycle pulse for a rejected window |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Downstream accepts the bundle |
| out_lane_vld | output | 3 | Per-lane valid |
| out_two_ops | output | 3 | Per-lane OP count flag |
| out_mop | output | 48 | Per-lane macro-op, lane k at bits k*16 upward |

## Verification
A wrong pending mask or a wrong head pointer shows up at the very next accepted bundle. The symptoms are:
- a slot repeated or skipped;
- a direct payload arriving in a ROM bundle;
- `win_ready` rising while slots are still owed, or staying low after the last one.

A wrong ROM sequencer address shows up within one bundle as a macro-op value out of sequence, or as a sequence that ends too early or too late. A stall that disturbs the state shows up one cycle later as lane contents changing under a low `out_ready`.

// File: rtl/ddm_pkg.sv
package ddm_pkg;

    localparam int DDM_SLOTS    = 6;
    localparam int DDM_LANES    = 3;
    localparam int DDM_MOP_W    = 16;
    localparam int DDM_ROM_AW   = 6;
    localparam int DDM_HALF_MAX = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOTS = 2'd1,
        ST_ROM   = 2'd2
    } ddm_state_e;

endpackage

// File: rtl/ddm_rom.sv
// Macro-op ROM with one read port per output lane; port k reads base + k.
// Content is computed: value {2'b11, zeros, addr}, OP flag addr[2],
// end-of-sequence when addr[1:0] == 2'b11.
module ddm_rom #(
    parameter int MOP_W  = 16,
    parameter int ROM_AW = 6,
    parameter int LANES  = 3
) (
    input  logic [ROM_AW-1:0]            base,
    output logic [LANES-1:0][MOP_W-1:0]  rd_mop,
    output logic [LANES-1:0]             rd_two_ops,
    output logic [LANES-1:0]             rd_eos
);

    localparam int PAD_W = MOP_W - ROM_AW - 2;

    for (genvar k = 0; k < LANES; k++) begin : g_port
        logic [ROM_AW-1:0] addr;
        assign addr          = base + ROM_AW'(k);
        assign rd_mop[k]     = {2'b11, {PAD_W{1'b0}}, addr};
        assign rd_two_ops[k] = addr[2];
        assign rd_eos[k]     = (addr[1:0] == 2'b11);
    end

endmodule

// File: rtl/ddm_half_check.sv
// Counts valid direct-path slots per 8-byte half and flags an overfull window.
module ddm_half_check #(
    parameter int SLOTS    = 6,
    parameter int HALF_MAX = 3
) (
    input  logic [SLOTS-1:0] slot_vld,
    input  logic [SLOTS-1:0] slot_vec,
    input  logic [SLOTS-1:0] slot_hi,
    output logic             overfull
);

    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;

    always_comb begin
        lo_cnt = '0;
        hi_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_vld[i] && !slot_vec[i]) begin
                if (slot_hi[i]) begin
                    hi_cnt = hi_cnt + CNT_W'(1);
                end else begin
                    lo_cnt = lo_cnt + CNT_W'(1);
                end
            end
        end
        overfull = (lo_cnt > CNT_W'(HALF_MAX)) || (hi_cnt > CNT_W'(HALF_MAX));
    end

endmodule

// File: rtl/ddm_direct_pick.sv
// Finds the oldest pending slot and gathers up to LANES consecutive
// pending direct slots, stopping at the first pending vector slot.
module ddm_direct_pick #(
    parameter int SLOTS  = 6,
    parameter int LANES  = 3,
    parameter int MOP_W  = 16,
    parameter int SIDX_W = 3
) (
    input  logic [SLOTS-1:0]             pend,
    input  logic [SLOTS-1:0]             slot_vec,
    input  logic [SLOTS-1:0]             slot_two_ops,
    input  logic [SLOTS-1:0][MOP_W-1:0]  slot_data,
    output logic                         head_found,
    output logic                         head_vec,
    output logic [SIDX_W-1:0]            head_idx,
    output logic [LANES-1:0]             lane_vld,
    output logic [LANES-1:0]             lane_two_ops,
    output logic [LANES-1:0][MOP_W-1:0]  lane_mop,
    output logic [SLOTS-1:0]             take
);

    localparam int LCNT_W = $clog2(LANES + 1);

    logic [LCNT_W-1:0] cnt;
    logic              stop;

    always_comb begin
        head_found   = 1'b0;
        head_vec     = 1'b0;
        head_idx     = '0;
        lane_vld     = '0;
        lane_two_ops = '0;
        lane_mop     = '0;
        take         = '0;
        cnt          = '0;
        stop         = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pend[i] && !stop) begin
                if (!head_found) begin
                    head_found = 1'b1;
                    head_vec   = slot_vec[i];
                    head_idx   = SIDX_W'(i);
                end
                if (slot_vec[i] || cnt == LCNT_W'(LANES)) begin
                    stop = 1'b1;
                end else begin
                    lane_vld[cnt]     = 1'b1;
                    lane_two_ops[cnt] = slot_two_ops[i];
                    lane_mop[cnt]     = slot_data[i];
                    take[i]           = 1'b1;
                    cnt               = cnt + LCNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dual_decode_merge.sv
module dual_decode_merge
    import ddm_pkg::*;
#(
    parameter int SLOTS    = DDM_SLOTS,
    parameter int LANES    = DDM_LANES,
    parameter int MOP_W    = DDM_MOP_W,
    parameter int ROM_AW   = DDM_ROM_AW,
    parameter int HALF_MAX = DDM_HALF_MAX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     win_valid,
    output logic                     win_ready,
    input  logic [SLOTS-1:0]         win_slot_vld,
    input  logic [SLOTS-1:0]         win_slot_vec,
    input  logic [SLOTS-1:0]         win_slot_hi,
    input  logic [SLOTS-1:0]         win_slot_two_ops,
    input  logic [SLOTS*MOP_W-1:0]   win_slot_data,
    output logic                     win_error,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES-1:0]         out_lane_vld,
    output logic [LANES-1:0]         out_two_ops,
    output logic [LANES*MOP_W-1:0]   out_mop
);

    localparam int SIDX_W = $clog2(SLOTS);

    // ---------------------------------------------------------------
    // State
    // ---------------------------------------------------------------
    ddm_state_e                  state_q, state_d;
    logic [SLOTS-1:0]            pend_q, pend_d;
    logic [ROM_AW-1:0]           pc_q, pc_d;
    logic [SLOTS-1:0]            vec_q;
    logic [SLOTS-1:0]            ops_q;
    logic [SLOTS-1:0][MOP_W-1:0] data_q;
    logic                        err_q;

    // ---------------------------------------------------------------
    // Submodule results
    // ---------------------------------------------------------------
    logic                        overfull;
    logic                        head_found;
    logic                        head_vec;
    logic [SIDX_W-1:0]           head_idx;
    logic [LANES-1:0]            dir_vld;
    logic [LANES-1:0]            dir_ops;
    logic [LANES-1:0][MOP_W-1:0] dir_mop;
    logic [SLOTS-1:0]            dir_take;

    logic [ROM_AW-1:0]           rom_base;
    logic [LANES-1:0][MOP_W-1:0] rom_mop;
    logic [LANES-1:0]            rom_ops;
    logic [LANES-1:0]            rom_eos;
    logic [LANES-1:0]            rom_live;
    logic                        rom_done;

    logic                        accept;
    logic                        fire;
    logic                        emit_rom;
    logic [SLOTS-1:0]            pend_after;
    logic [LANES-1:0][MOP_W-1:0] lane_mop;

    ddm_half_check #(
        .SLOTS    (SLOTS),
        .HALF_MAX (HALF_MAX)
    ) u_half_check (
        .slot_vld (win_slot_vld),
        .slot_vec (win_slot_vec),
        .slot_hi  (win_slot_hi),
        .overfull (overfull)
    );

    ddm_direct_pick #(
        .SLOTS  (SLOTS),
        .LANES  (LANES),
        .MOP_W  (MOP_W),
        .SIDX_W (SIDX_W)
    ) u_direct_pick (
        .pend         (pend_q),
        .slot_vec     (vec_q),
        .slot_two_ops (ops_q),
        .slot_data    (data_q),
        .head_found   (head_found),
        .head_vec     (head_vec),
        .head_idx     (head_idx),
        .lane_vld     (dir_vld),
        .lane_two_ops (dir_ops),
        .lane_mop     (dir_mop),
        .take         (dir_take)
    );

    assign rom_base = (state_q == ST_ROM) ? pc_q : data_q[head_idx][ROM_AW-1:0];

    ddm_rom #(
        .MOP_W  (MOP_W),
        .ROM_AW (ROM_AW),
        .LANES  (LANES)
    ) u_rom (
        .base       (rom_base),
        .rd_mop     (rom_mop),
        .rd_two_ops (rom_ops),
        .rd_eos     (rom_eos)
    );

    // A ROM lane is live until the end-of-sequence word, inclusive.
    always_comb begin
        logic alive;
        alive = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            rom_live[k] = alive;
            if (rom_eos[k]) begin
                alive = 1'b0;
            end
        end
    end
    assign rom_done = |rom_eos;

    assign emit_rom  = (state_q == ST_ROM) ||
                       ((state_q == ST_SLOTS) && head_found && head_vec);
    assign win_ready = (state_q == ST_IDLE) && !flush;
    assign accept    = win_valid && win_ready;
    assign fire      = out_valid && out_ready;
    assign win_error = err_q;

    // ---------------------------------------------------------------
    // Output process
    // ---------------------------------------------------------------
    always_comb begin
        out_lane_vld = '0;
        out_two_ops  = '0;
        lane_mop     = '0;
        unique case (state_q)
            ST_IDLE: begin
                out_lane_vld = '0;
            end
            ST_SLOTS, ST_ROM: begin
                if (emit_rom) begin
                    for (int k = 0; k < LANES; k++) begin
                        out_lane_vld[k] = rom_live[k];
                        out_two_ops[k]  = rom_live[k] & rom_ops[k];
                        lane_mop[k]     = rom_live[k] ? rom_mop[k] : '0;
                    end
                end else begin
                    out_lane_vld = dir_vld;
                    out_two_ops  = dir_ops;
                    lane_mop     = dir_mop;
                end
            end
            default: begin
                out_lane_vld = '0;
            end
        endcase
    end

    assign out_mop   = lane_mop;
    assign out_valid = |out_lane_vld;

    // ---------------------------------------------------------------
    // Next-state process
    // ---------------------------------------------------------------
    always_comb begin
        state_d    = state_q;
        pend_d     = pend_q;
        pc_d       = pc_q;
        pend_after = pend_q & ~(SLOTS'(1) << head_idx);
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !overfull && (|win_slot_vld)) begin
                    state_d = ST_SLOTS;
                    pend_d  = win_slot_vld;
                end
            end
            ST_SLOTS: begin
                if (fire) begin
                    if (head_vec) begin
                        if (rom_done) begin
                            pend_d  = pend_after;
                            state_d = (|pend_after) ? ST_SLOTS : ST_IDLE;
                        end else begin
                            pc_d    = rom_base + ROM_AW'(LANES);
                            state_d = ST_ROM;
                        end
                    end else begin
                        pend_d  = pend_q & ~dir_take;
                        state_d = (|(pend_q & ~dir_take)) ? ST_SLOTS : ST_IDLE;
                    end
                end
            end
            ST_ROM: begin
                if (fire) begin
                    if (rom_done) begin
                        pend_d  = pend_after;
                        state_d = (|pend_after) ? ST_SLOTS : ST_IDLE;
                    end else begin
                        pc_d = pc_q + ROM_AW'(LANES);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (flush) begin
            state_d = ST_IDLE;
            pend_d  = '0;
        end
    end

    // ---------------------------------------------------------------
    // State register process
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            pc_q    <= '0;
            vec_q   <= '0;
            ops_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pc_q    <= pc_d;
            err_q   <= accept && overfull;
            if (accept) begin
                vec_q  <= win_slot_vec;
                ops_q  <= win_slot_two_ops;
                data_q <= win_slot_data;
            end
        end
    end

endmodule

// File: rtl/ddm_checker.sv
module ddm_checker #(
    parameter int LANES = 3,
    parameter int MOP_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush,
    input logic                   win_valid,
    input logic                   win_ready,
    input logic                   win_error,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES-1:0]       out_lane_vld,
    input logic [LANES-1:0]       out_two_ops,
    input logic [LANES*MOP_W-1:0] out_mop
);

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !win_ready); // R2

    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_lane_vld & (out_lane_vld + LANES'(1))) == '0) && (out_valid == (|out_lane_vld))); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            ($stable(out_lane_vld) && $stable(out_mop) && $stable(out_two_ops))); // R7

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        win_error |-> !out_valid); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_error |-> $past(win_valid && win_ready)); // R8

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R9

    AST_FLUSH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !win_ready); // R9

endmodule

bind dual_decode_merge ddm_checker #(
    .LANES (LANES),
    .MOP_W (MOP_W)
) u_ddm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .win_valid    (win_valid),
    .win_ready    (win_ready),
    .win_error    (win_error),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_lane_vld (out_lane_vld),
    .out_two_ops  (out_two_ops),
    .out_mop      (out_mop)
);

// File: tb/test_dual_decode_merge.sv
`timescale 1ns/1ps
module test_dual_decode_merge;

    localparam int SLOTS = 6;
    localparam int LANES = 3;
    localparam int MOP_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   flush;
    logic                   win_valid;
    logic                   win_ready;
    logic [SLOTS-1:0]       win_slot_vld;
    logic [SLOTS-1:0]       win_slot_vec;
    logic [SLOTS-1:0]       win_slot_hi;
    logic [SLOTS-1:0]       win_slot_two_ops;
    logic [SLOTS*MOP_W-1:0] win_slot_data;
    logic                   win_error;
    logic                   out_valid;
    logic                   out_ready;
    logic [LANES-1:0]       out_lane_vld;
    logic [LANES-1:0]       out_two_ops;
    logic [LANES*MOP_W-1:0] out_mop;

    always #2.5 clk = ~clk;

    dual_decode_merge i_dual_decode_merge (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush            (flush),
        .win_valid        (win_valid),
        .win_ready        (win_ready),
        .win_slot_vld     (win_slot_vld),
        .win_slot_vec     (win_slot_vec),
        .win_slot_hi      (win_slot_hi),
        .win_slot_two_ops (win_slot_two_ops),
        .win_slot_data    (win_slot_data),
        .win_error        (win_error),
        .out_valid        (out_valid),
        .out_ready        (out_ready),
        .out_lane_vld     (out_lane_vld),
        .out_two_ops      (out_two_ops),
        .out_mop          (out_mop)
    );

    int checks   = 0;
    int failures = 0;

    // Window under construction
    logic             t_vld [SLOTS];
    logic             t_vec [SLOTS];
    logic             t_hi  [SLOTS];
    logic             t_ops [SLOTS];
    logic [MOP_W-1:0] t_data[SLOTS];

    // Expected bundles
    logic [LANES-1:0]       q_vld[$];
    logic [LANES-1:0]       q_ops[$];
    logic [LANES*MOP_W-1:0] q_mop[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_window();
        for (int i = 0; i < SLOTS; i++) begin
            t_vld[i] = 1'b0; t_vec[i] = 1'b0; t_hi[i] = 1'b0; t_ops[i] = 1'b0; t_data[i] = '0;
        end
    endtask

    task automatic set_slot(input int i, input bit vec, input bit hi, input bit ops, input logic [MOP_W-1:0] d);
        t_vld[i] = 1'b1; t_vec[i] = vec; t_hi[i] = hi; t_ops[i] = ops; t_data[i] = d;
    endtask

    // Expected bundle list from R3..R6: ROM word a = 16'hC000|a, flag a[2], ends at a[1:0]==3.
    task automatic build_expected();
        logic [LANES-1:0]       bv;
        logic [LANES-1:0]       bo;
        logic [LANES*MOP_W-1:0] bm;
        logic [5:0]             a;
        int                     n;
        int                     i;
        bit                     done;
        q_vld.delete(); q_ops.delete(); q_mop.delete();
        i = 0;
        while (i < SLOTS) begin
            if (!t_vld[i]) begin
                i++;
            end else if (t_vec[i]) begin
                a = t_data[i][5:0]; done = 1'b0; bv = '0; bo = '0; bm = '0; n = 0;
                while (!done) begin
                    bv[n] = 1'b1;
                    bo[n] = a[2];
                    bm[n*MOP_W +: MOP_W] = 16'hC000 | {10'd0, a};
                    done = (a[1:0] == 2'b11);
                    a = a + 6'd1;
                    n++;
                    if (done || n == LANES) begin
                        q_vld.push_back(bv); q_ops.push_back(bo); q_mop.push_back(bm);
                        bv = '0; bo = '0; bm = '0; n = 0;
                    end
                end
                i++;
            end else begin
                bv = '0; bo = '0; bm = '0; n = 0;
                while (i < SLOTS && n < LANES) begin
                    if (!t_vld[i]) begin
                        i++;
                    end else if (t_vec[i]) begin
                        break;
                    end else begin
                        bv[n] = 1'b1;
                        bo[n] = t_ops[i];
                        bm[n*MOP_W +: MOP_W] = t_data[i];
                        n++;
                        i++;
                    end
                end
                q_vld.push_back(bv); q_ops.push_back(bo); q_mop.push_back(bm);
            end
        end
    endtask

    // Offers the window at a negedge; returns just after the accepting edge.
    task automatic send_window();
        @(negedge clk);
        for (int i = 0; i < SLOTS; i++) begin
            win_slot_vld[i]               = t_vld[i];
            win_slot_vec[i]               = t_vec[i];
            win_slot_hi[i]                = t_hi[i];
            win_slot_two_ops[i]           = t_ops[i];
            win_slot_data[i*MOP_W +: MOP_W] = t_data[i];
        end
        win_valid = 1'b1;
        @(posedge clk);
        #1;
        win_valid = 1'b0;
    endtask

    // Collects bundles, comparing each with the expected list.
    task automatic collect(input string tag, input bit stall);
        int                     bi;
        int                     cyc;
        bit                     hold;
        bit                     rdy;
        logic [LANES-1:0]       s_vld;
        logic [LANES-1:0]       s_ops;
        logic [LANES*MOP_W-1:0] s_mop;
        bi = 0; cyc = 0; hold = 1'b0;
        s_vld = '0; s_ops = '0; s_mop = '0;
        while (bi < q_vld.size() && cyc < 300) begin
            @(negedge clk);
            if (hold) begin
                check(out_lane_vld == s_vld && out_mop == s_mop && out_two_ops == s_ops,
                      "R7 stall hold", {16'd0, out_mop}, {16'd0, s_mop});
            end
            rdy = stall ? (cyc % 3 == 2) : 1'b1;
            out_ready = rdy;
            check(win_ready == 1'b0, "R2 busy", 64'(win_ready), 64'd0);
            if (out_valid && rdy) begin
                check(out_lane_vld == q_vld[bi], {"R3 R5 lanes ", tag}, 64'(out_lane_vld), 64'(q_vld[bi]));
                check(out_mop == q_mop[bi], {"R4 R6 mop ", tag}, 64'(out_mop), 64'(q_mop[bi]));
                check(out_two_ops == q_ops[bi], {"R3 R4 ops ", tag}, 64'(out_two_ops), 64'(q_ops[bi]));
                bi++;
            end
            hold  = out_valid && !rdy;
            s_vld = out_lane_vld; s_ops = out_two_ops; s_mop = out_mop;
            cyc++;
        end
        check(bi == q_vld.size(), {"R6 bundle count ", tag}, 64'(bi), 64'(q_vld.size()));
        out_ready = 1'b1;
        @(negedge clk);
        check(win_ready == 1'b1 && out_valid == 1'b0, {"R2 ready after drain ", tag},
              {62'd0, win_ready, out_valid}, 64'd2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; flush = 1'b0; win_valid = 1'b0; out_ready = 1'b1;
        win_slot_vld = '0; win_slot_vec = '0; win_slot_hi = '0; win_slot_two_ops = '0; win_slot_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(win_ready == 1'b1, "R1 win_ready", 64'(win_ready), 64'd1);
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(win_error == 1'b0, "R1 win_error", 64'(win_error), 64'd0);
    endtask

    // Six direct slots, three per half: the legal limit.
    task automatic t_all_direct();
        clear_window();
        for (int i = 0; i < SLOTS; i++) begin
            set_slot(i, 1'b0, (i >= 3), i[0], MOP_W'(16'h1000 + i));
        end
        build_expected();
        send_window();
        check(win_error == 1'b0, "R8 legal limit no error", 64'(win_error), 64'd0);
        collect("direct", 1'b0);
    endtask

    // Interleaved direct/vector with a hole (R3 skip, R4 multi-bundle, R5).
    task automatic t_mixed(input bit stall);
        clear_window();
        set_slot(0, 1'b0, 1'b0, 1'b1, 16'h1111);
        set_slot(1, 1'b1, 1'b0, 1'b0, 16'h0002);
        set_slot(3, 1'b0, 1'b1, 1'b0, 16'h2222);
        set_slot(4, 1'b0, 1'b1, 1'b1, 16'h3333);
        set_slot(5, 1'b1, 1'b1, 1'b0, 16'h0008);
        build_expected();
        send_window();
        collect(stall ? "mixed stall" : "mixed", stall);
    endtask

    // Vector at the head, then four direct slots split over two bundles.
    task automatic t_vector_head();
        clear_window();
        set_slot(0, 1'b1, 1'b0, 1'b0, 16'h0005);
        set_slot(1, 1'b0, 1'b0, 1'b1, 16'h4001);
        set_slot(2, 1'b0, 1'b0, 1'b0, 16'h4002);
        set_slot(3, 1'b0, 1'b1, 1'b1, 16'h4003);
        set_slot(4, 1'b0, 1'b1, 1'b0, 16'h4004);
        build_expected();
        send_window();
        collect("vector head", 1'b0);
    endtask

    // Four direct slots in the lower half: rejected (R8).
    task automatic t_overfull();
        clear_window();
        for (int i = 0; i < 4; i++) begin
            set_slot(i, 1'b0, 1'b0, 1'b0, MOP_W'(16'h5000 + i));
        end
        set_slot(4, 1'b0, 1'b1, 1'b0, 16'h5004);
        send_window();
        @(negedge clk);
        check(win_error == 1'b1, "R8 error pulse", 64'(win_error), 64'd1);
        check(out_valid == 1'b0, "R8 no output", 64'(out_valid), 64'd0);
        check(win_ready == 1'b1, "R8 still ready", 64'(win_ready), 64'd1);
        @(negedge clk);
        check(win_error == 1'b0, "R8 pulse one cycle", 64'(win_error), 64'd0);
        check(out_valid == 1'b0, "R8 window dropped", 64'(out_valid), 64'd0);
    endtask

    // Flush in the middle of a four-word ROM sequence (R9).
    task automatic t_flush();
        clear_window();
        set_slot(0, 1'b1, 1'b0, 1'b0, 16'h0008);
        set_slot(1, 1'b0, 1'b0, 1'b0, 16'h6001);
        send_window();
        @(negedge clk);
        check(out_valid == 1'b1, "R4 sequence started", 64'(out_valid), 64'd1);
        out_ready = 1'b0;
        flush     = 1'b1;
        #1;
        check(win_ready == 1'b0, "R9 not ready during flush", 64'(win_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9 output cleared", 64'(out_valid), 64'd0);
        check(win_ready == 1'b1, "R9 ready after flush", 64'(win_ready), 64'd1);
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R9 sequence aborted", 64'(out_valid), 64'd0);
        t_mixed(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_all_direct();
        t_mixed(1'b0);
        t_mixed(1'b1);
        t_vector_head();
        t_overfull();
        t_flush();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule